// File: doc/BRIEF.md
# Host Mailbox with Indirect Shared-Memory Port

This block is a byte-wide register file that sits between a host processor and an embedded sequencing engine. The two share a small SRAM. The host never sees that memory directly. It loads a pointer register and then moves bytes through a single data window. The block also carries a mailbox. The host names a program entry point, raises a request flag, and then follows a four-phase exchange with the engine: request up, acknowledge up, request down, acknowledge down. If the engine cannot run the program, it raises a sticky error flag in place of the acknowledge.

On the engine side there are three strobes: accept, fail and finish. The engine also has its own read/write port into the shared SRAM. While a mailbox exchange is open, the engine owns the SRAM, and host writes through the data window are dropped. A version-query pair lets software identify the block. Writing a key value to the select register makes the data register return the version code.

Top module: `hmbx_top`

## Requirements
- R1: After reset, the pointer (0x12), command (0x14), message (0x15), version-select (0x16) and status (0x18) registers all read 0x00, and `eng_start` is low.
- R2: A host write to offset 0x12 loads the SRAM pointer. A host write to 0x13 then stores the byte at that pointer, and a host read of 0x13 returns the byte at that pointer. Read data appears on `hst_rdata` in the cycle after the read is sampled and holds until the next read.
- R3: Bit 0 of the command register (0x14) is the request flag. When a host write sets it from 0 to 1, `eng_start` is high for exactly the next cycle. Writing 1 while the flag is already 1 gives no pulse.
- R4: In the status register (0x18), bit 0 is the acknowledge and bit 1 is the error. The status register updates one cycle after the engine strobe. `eng_accept` sets the acknowledge only while the request flag is set; otherwise it is ignored. `eng_err` sets the error only while the request flag is set, and the acknowledge stays clear.
- R5: `eng_done` clears the acknowledge, which completes the exchange.
- R6: The error bit stays set after the host drops the request. It clears on the edge at which the next request is raised.
- R7: While the request flag or the acknowledge is set, host writes to 0x13 leave the SRAM unchanged. Host reads of 0x13 still return stored data.
- R8: When the version-select register (0x16) holds 0x1F, a read of 0x17 returns 0x01. With any other select value, a read of 0x17 returns 0x00.
- R9: The message register (0x15) reads back what was written, and `eng_pc` always shows it. The status register ignores host writes. Unmapped offsets read 0x00.
- R10: The engine port writes the SRAM with `eng_mem_we`, and the host sees the result. `eng_mem_rdata` returns the byte at `eng_mem_addr` one cycle after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hst_we | input | 1 | Host register write strobe |
| hst_rd | input | 1 | Host register read strobe |
| hst_addr | input | OW | Host register offset |
| hst_wdata | input | DW | Host write data |
| hst_rdata | output | DW | Host read data, registered |
| eng_start | output | 1 | One-cycle pulse when a request is raised |
| eng_pc | output | DW | Program entry point from the message register |
| eng_accept | input | 1 | Engine accepts the request (sets acknowledge) |
| eng_err | input | 1 | Engine rejects the request (sets error) |
| eng_done | input | 1 | Engine finished (clears acknowledge) |
| eng_mem_we | input | 1 | Engine SRAM write enable |
| eng_mem_addr | input | AW | Engine SRAM address |
| eng_mem_wdata | input | DW | Engine SRAM write data |
| eng_mem_rdata | output | DW | Engine SRAM read data, one cycle latency |

## Verification
Each result has a fixed due cycle:
- Host read data, the status bits and the request flag are all due one clock after the edge that samples the stimulus.
- `eng_start` is high in the cycle after the command write and low again one cycle later.
- Engine read data follows its address by one edge.

The bench drives every input on the falling edge and samples outputs on the following falling edge, half a period after the edge that updates them. Each check lands in its due cycle, and the bench never samples at an edge.

// File: rtl/hmbx_pkg.sv
package hmbx_pkg;
   // Register offsets decoded by the host bus
   localparam logic [7:0] OFS_PTR  = 8'h12;
   localparam logic [7:0] OFS_DATA = 8'h13;
   localparam logic [7:0] OFS_CMD  = 8'h14;
   localparam logic [7:0] OFS_MSG  = 8'h15;
   localparam logic [7:0] OFS_VSEL = 8'h16;
   localparam logic [7:0] OFS_VDAT = 8'h17;
   localparam logic [7:0] OFS_STAT = 8'h18;

   // Status bit positions
   localparam int STAT_ACK = 0;
   localparam int STAT_ERR = 1;

   typedef enum logic [2:0] {
      SEL_NONE, SEL_PTR, SEL_DATA, SEL_CMD, SEL_MSG, SEL_VSEL, SEL_VDAT, SEL_STAT
   } reg_sel_e;
endpackage

// File: rtl/hmbx_sram.sv
module hmbx_sram #(
   parameter int AW = 8,
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          h_we,
   input  logic [AW-1:0] h_addr,
   input  logic [DW-1:0] h_wdata,
   output logic [DW-1:0] h_rdata,
   input  logic          e_we,
   input  logic [AW-1:0] e_addr,
   input  logic [DW-1:0] e_wdata,
   output logic [DW-1:0] e_rdata
);
   localparam int DEPTH = 1 << AW;

   logic [DW-1:0] mem [DEPTH];

   // engine write takes priority on a same-address collision
   always_ff @(posedge clk) begin
      if (h_we && !(e_we && (e_addr == h_addr)))
         mem[h_addr] <= h_wdata;
      if (e_we)
         mem[e_addr] <= e_wdata;
      e_rdata <= mem[e_addr];
   end

   assign h_rdata = mem[h_addr];
endmodule

// File: rtl/hmbx_handshake.sv
module hmbx_handshake #(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cmd_we,
   input  logic          cmd_bit,
   input  logic          msg_we,
   input  logic [DW-1:0] msg_wdata,
   input  logic          eng_accept,
   input  logic          eng_err,
   input  logic          eng_done,
   output logic          req,
   output logic          ack,
   output logic          err,
   output logic [DW-1:0] msg,
   output logic          eng_start,
   output logic          owned
);
   logic req_d;
   logic req_set;

   assign req_set = cmd_we && cmd_bit && !req;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req   <= 1'b0;
         req_d <= 1'b0;
         ack   <= 1'b0;
         err   <= 1'b0;
         msg   <= '0;
      end else begin
         req_d <= req;
         if (cmd_we)
            req <= cmd_bit;
         if (msg_we)
            msg <= msg_wdata;
         if (eng_done)
            ack <= 1'b0;
         else if (eng_accept && req && !eng_err)
            ack <= 1'b1;
         if (req_set)
            err <= 1'b0;
         else if (eng_err && req)
            err <= 1'b1;
      end
   end

   assign eng_start = req && !req_d;
   assign owned     = req || ack;

   // R3
   start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      eng_start |=> !eng_start);
   // R6
   err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(req) |-> !err);
   // R4
   ack_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ack) |-> $past(eng_accept) && $past(req));
   // R5
   ack_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ack) |-> $past(eng_done));
endmodule

// File: rtl/hmbx_regs.sv
module hmbx_regs
   import hmbx_pkg::*;
#(
   parameter int          AW          = 8,
   parameter int          DW          = 8,
   parameter int          OW          = 8,
   parameter logic [7:0]  VERSION_KEY = 8'h1F,
   parameter logic [7:0]  VERSION_ID  = 8'h01,
   parameter bit          OUT_REG     = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic          rd,
   input  logic [OW-1:0] off,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] rdata,
   input  logic          owned,
   input  logic          req,
   input  logic          ack,
   input  logic          err,
   input  logic [DW-1:0] msg,
   input  logic [DW-1:0] mem_rdata,
   output logic [AW-1:0] ptr,
   output logic          mem_we,
   output logic          cmd_we,
   output logic          msg_we
);
   reg_sel_e      sel;
   logic [DW-1:0] vsel;
   logic [DW-1:0] mux;

   always_comb begin
      if      (off == OW'(OFS_PTR))  sel = SEL_PTR;
      else if (off == OW'(OFS_DATA)) sel = SEL_DATA;
      else if (off == OW'(OFS_CMD))  sel = SEL_CMD;
      else if (off == OW'(OFS_MSG))  sel = SEL_MSG;
      else if (off == OW'(OFS_VSEL)) sel = SEL_VSEL;
      else if (off == OW'(OFS_VDAT)) sel = SEL_VDAT;
      else if (off == OW'(OFS_STAT)) sel = SEL_STAT;
      else                           sel = SEL_NONE;
   end

   assign mem_we = we && (sel == SEL_DATA) && !owned;
   assign cmd_we = we && (sel == SEL_CMD);
   assign msg_we = we && (sel == SEL_MSG);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr  <= '0;
         vsel <= '0;
      end else if (we) begin
         if (sel == SEL_PTR)
            ptr <= wdata[AW-1:0];
         if (sel == SEL_VSEL)
            vsel <= wdata;
      end
   end

   always_comb begin
      mux = '0;
      unique case (sel)
         SEL_PTR:  mux = DW'(ptr);
         SEL_DATA: mux = mem_rdata;
         SEL_CMD:  mux = DW'(req);
         SEL_MSG:  mux = msg;
         SEL_VSEL: mux = vsel;
         SEL_VDAT: mux = (vsel == DW'(VERSION_KEY)) ? DW'(VERSION_ID) : '0;
         SEL_STAT: begin
            mux[STAT_ACK] = ack;
            mux[STAT_ERR] = err;
         end
         default:  mux = '0;
      endcase
   end

   generate
      if (OUT_REG) begin : g_rd_reg
         logic [DW-1:0] rdata_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               rdata_q <= '0;
            else if (rd)
               rdata_q <= mux;
         end
         assign rdata = rdata_q;

         // R8
         version_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (rd && (sel == SEL_VDAT) && (vsel == DW'(VERSION_KEY)))
               |=> (rdata == DW'(VERSION_ID)));
         // R2
         rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !rd |=> $stable(rdata));
      end else begin : g_rd_comb
         assign rdata = mux;
      end
   endgenerate
endmodule

// File: rtl/hmbx_top.sv
module hmbx_top #(
   parameter int          AW          = 8,
   parameter int          DW          = 8,
   parameter int          OW          = 8,
   parameter logic [7:0]  VERSION_KEY = 8'h1F,
   parameter logic [7:0]  VERSION_ID  = 8'h01,
   parameter bit          OUT_REG     = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          hst_we,
   input  logic          hst_rd,
   input  logic [OW-1:0] hst_addr,
   input  logic [DW-1:0] hst_wdata,
   output logic [DW-1:0] hst_rdata,
   output logic          eng_start,
   output logic [DW-1:0] eng_pc,
   input  logic          eng_accept,
   input  logic          eng_err,
   input  logic          eng_done,
   input  logic          eng_mem_we,
   input  logic [AW-1:0] eng_mem_addr,
   input  logic [DW-1:0] eng_mem_wdata,
   output logic [DW-1:0] eng_mem_rdata
);
   generate
      if (DW < 2) begin : g_bad_dw
         $error("hmbx_top: DW must hold the acknowledge and error bits");
      end
      if (AW > DW) begin : g_bad_aw
         $error("hmbx_top: SRAM pointer must fit in one data byte");
      end
      if (OW < 5) begin : g_bad_ow
         $error("hmbx_top: offset width too small for the register map");
      end
   endgenerate

   logic          req, ack, err, owned;
   logic          mem_we, cmd_we, msg_we;
   logic [AW-1:0] ptr;
   logic [DW-1:0] msg, mem_rdata;

   hmbx_regs #(
      .AW(AW), .DW(DW), .OW(OW),
      .VERSION_KEY(VERSION_KEY), .VERSION_ID(VERSION_ID), .OUT_REG(OUT_REG)
   ) i_regs (
      .clk(clk), .rst_n(rst_n), .we(hst_we), .rd(hst_rd), .off(hst_addr),
      .wdata(hst_wdata), .rdata(hst_rdata), .owned(owned), .req(req),
      .ack(ack), .err(err), .msg(msg), .mem_rdata(mem_rdata), .ptr(ptr),
      .mem_we(mem_we), .cmd_we(cmd_we), .msg_we(msg_we)
   );

   hmbx_handshake #(.DW(DW)) i_hs (
      .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_bit(hst_wdata[0]),
      .msg_we(msg_we), .msg_wdata(hst_wdata), .eng_accept(eng_accept),
      .eng_err(eng_err), .eng_done(eng_done), .req(req), .ack(ack),
      .err(err), .msg(msg), .eng_start(eng_start), .owned(owned)
   );

   hmbx_sram #(.AW(AW), .DW(DW)) i_sram (
      .clk(clk), .h_we(mem_we), .h_addr(ptr), .h_wdata(hst_wdata),
      .h_rdata(mem_rdata), .e_we(eng_mem_we), .e_addr(eng_mem_addr),
      .e_wdata(eng_mem_wdata), .e_rdata(eng_mem_rdata)
   );

   assign eng_pc = msg;

   // R7
   owned_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hst_we && (hst_addr == OW'(8'h13)) && (req || ack)) |-> !mem_we);
endmodule

// File: tb/test_hmbx_top.sv
`timescale 1ns/1ps
module test_hmbx_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       hst_we = 1'b0, hst_rd = 1'b0;
   logic [7:0] hst_addr = '0, hst_wdata = '0;
   logic [7:0] hst_rdata;
   logic       eng_start;
   logic [7:0] eng_pc;
   logic       eng_accept = 1'b0, eng_err = 1'b0, eng_done = 1'b0;
   logic       eng_mem_we = 1'b0;
   logic [7:0] eng_mem_addr = '0, eng_mem_wdata = '0;
   logic [7:0] eng_mem_rdata;

   int total = 0;
   int bad = 0;
   bit finished = 0;

   always #2.5 clk = ~clk;

   hmbx_top i_hmbx_top (
      .clk(clk), .rst_n(rst_n), .hst_we(hst_we), .hst_rd(hst_rd),
      .hst_addr(hst_addr), .hst_wdata(hst_wdata), .hst_rdata(hst_rdata),
      .eng_start(eng_start), .eng_pc(eng_pc), .eng_accept(eng_accept),
      .eng_err(eng_err), .eng_done(eng_done), .eng_mem_we(eng_mem_we),
      .eng_mem_addr(eng_mem_addr), .eng_mem_wdata(eng_mem_wdata),
      .eng_mem_rdata(eng_mem_rdata)
   );

   // op[31:28] 0=write 1=read+check, req[27:24], offset, wdata, expected
   localparam int NV = 22;
   localparam logic [31:0] VEC [NV] = '{
      32'h0_2_12_05_00, 32'h0_2_13_A5_00, 32'h0_2_12_06_00, 32'h0_2_13_3C_00,
      32'h0_2_12_07_00, 32'h0_2_13_11_00, 32'h0_2_12_05_00, 32'h1_2_13_00_A5,
      32'h0_2_12_06_00, 32'h1_2_13_00_3C, 32'h1_2_12_00_06, 32'h0_9_15_4E_00,
      32'h1_9_15_00_4E, 32'h0_8_16_1F_00, 32'h1_8_17_00_01, 32'h0_8_16_1E_00,
      32'h1_8_17_00_00, 32'h0_9_18_FF_00, 32'h1_9_18_00_00, 32'h1_9_40_00_00,
      32'h1_8_16_00_1E, 32'h1_9_14_00_00
   };

   task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] o, input logic [7:0] d);
      hst_we = 1'b1; hst_addr = o; hst_wdata = d;
      @(negedge clk);
      hst_we = 1'b0;
   endtask

   task automatic rd(input logic [7:0] o, output logic [7:0] v);
      hst_rd = 1'b1; hst_addr = o;
      @(negedge clk);
      hst_rd = 1'b0;
      v = hst_rdata;
   endtask

   task automatic strobe(input int which);
      if (which == 0) eng_accept = 1'b1;
      else if (which == 1) eng_err = 1'b1;
      else eng_done = 1'b1;
      @(negedge clk);
      eng_accept = 1'b0; eng_err = 1'b0; eng_done = 1'b0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         bad++; total++;
         $display("FAIL watchdog: actual=hung expected=done");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [7:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      check({7'd0, eng_start}, 8'h00, "R1 eng_start");
      rd(8'h12, v); check(v, 8'h00, "R1 ptr");
      rd(8'h14, v); check(v, 8'h00, "R1 cmd");
      rd(8'h15, v); check(v, 8'h00, "R1 msg");
      rd(8'h16, v); check(v, 8'h00, "R1 vsel");
      rd(8'h18, v); check(v, 8'h00, "R1 status");

      // table: R2 R8 R9
      for (int i = 0; i < NV; i++) begin
         if (VEC[i][31:28] == 4'd0)
            wr(VEC[i][23:16], VEC[i][15:8]);
         else begin
            rd(VEC[i][23:16], v);
            check(v, VEC[i][7:0], $sformatf("R%0d vec%0d", VEC[i][27:24], i));
         end
      end

      // R3 request raise and start pulse
      wr(8'h15, 8'h20);
      wr(8'h14, 8'h01);
      check({7'd0, eng_start}, 8'h01, "R3 start pulse");
      check(eng_pc, 8'h20, "R9 eng_pc");
      @(negedge clk);
      check({7'd0, eng_start}, 8'h00, "R3 pulse one cycle");
      wr(8'h14, 8'h01);
      check({7'd0, eng_start}, 8'h00, "R3 no pulse when already set");
      rd(8'h14, v); check(v, 8'h01, "R3 request readback");

      // R7 host data write blocked while request set
      wr(8'h12, 8'h07);
      wr(8'h13, 8'h77);
      strobe(0);
      rd(8'h18, v); check(v, 8'h01, "R4 ack set");
      wr(8'h14, 8'h00);
      rd(8'h18, v); check(v, 8'h01, "R4 ack holds after request drop");
      wr(8'h13, 8'h88);
      rd(8'h13, v); check(v, 8'h11, "R7 writes ignored, reads allowed");

      // R10 engine port
      eng_mem_we = 1'b1; eng_mem_addr = 8'h05; eng_mem_wdata = 8'h99;
      @(negedge clk);
      eng_mem_we = 1'b0; eng_mem_addr = 8'h06;
      @(negedge clk);
      check(eng_mem_rdata, 8'h3C, "R10 engine read");
      strobe(2);
      rd(8'h18, v); check(v, 8'h00, "R5 ack dropped");
      wr(8'h12, 8'h05);
      rd(8'h13, v); check(v, 8'h99, "R10 engine write seen by host");
      wr(8'h13, 8'h5A);
      rd(8'h13, v); check(v, 8'h5A, "R7 writes allowed when idle");

      // R4 accept ignored without request
      strobe(0);
      rd(8'h18, v); check(v, 8'h00, "R4 accept without request");

      // R6 error path
      wr(8'h14, 8'h01);
      strobe(1);
      rd(8'h18, v); check(v, 8'h02, "R4 error sets err only");
      wr(8'h14, 8'h00);
      rd(8'h18, v); check(v, 8'h02, "R6 error sticky");
      wr(8'h14, 8'h01);
      rd(8'h18, v); check(v, 8'h00, "R6 error cleared by new request");
      strobe(0);
      wr(8'h14, 8'h00);
      strobe(2);
      rd(8'h18, v); check(v, 8'h00, "R5 exchange closed");

      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule